// File: doc/BRIEF.md
# ALU with Status and Control Flag Word

This block pairs a 16-bit arithmetic and logic unit with a flag register. Each clock the unit takes two operands, a function code and a size bit. It registers the result together with a carry indication, a zero indication and an unsigned greater-than comparison of the two operands. When the update strobe is high, the same edge also captures the status flags in the flag word: carry, parity, auxiliary carry, zero, sign and overflow.

Three control flags sit in the same word: trap, interrupt enable and direction. Arithmetic never touches them. They change only through per-flag set and clear strobes. In byte mode the unit works on the low eight bits of each operand. It reads the sign, carry and overflow at bit 7, and the upper result byte reads zero.

Top module: `alu_flag_unit`

## Requirements
- R1: `op_sel` encoding is 0 add, 1 subtract (A-B), 2 decrement A, 3 AND, 4 OR, 5 XOR, 6 NOT A, 7 shift left by one, 8 logical shift right by one, 9 arithmetic shift right by one. For add and subtract, `result_q` is the sum or difference modulo the active width. `carry_q` and CF (flag bit 0) hold the carry out, or for subtract the borrow.
- R2: Decrement yields A-1. `carry_q` reports the borrow (A was zero). CF keeps its previous value even when `flag_wr` is high.
- R3: AND, OR, XOR and NOT produce the bitwise result. They drive `carry_q` low and clear CF, AF (bit 4) and OF (bit 11) on update.
- R4: For the three shifts, the bit shifted out (MSB for left, bit 0 for right) appears on `carry_q` and in CF. The arithmetic right shift keeps the sign bit, the logical one shifts in zero, and AF and OF are cleared.
- R5: ZF (bit 6) is set when the active-width result is zero. SF (bit 7) copies the result MSB of the active width. PF (bit 2) is set when the low result byte holds an even number of ones.
- R6: AF is the carry or borrow out of bit 3 for add, subtract and decrement. OF is set on signed overflow of those three operations.
- R7: With `byte_mode` high, operand bits 15:8 are ignored and `result_q[15:8]` reads zero. Carry, sign and overflow are taken at bit 7.
- R8: `zero_q` is high when the registered result is zero. `a_gt_b_q` is high when A is greater than B, both taken unsigned over the active width.
- R9: The status flags change only on an edge where `flag_wr` is high.
- R10: `ctl_set[i]` and `ctl_clr[i]` set and clear control flag i: index 0 is TF (bit 8), 1 is IF (bit 9) and 2 is DF (bit 10). Set wins when both are high. No ALU operation changes these flags.
- R11: Synchronous reset drives every output to zero except `flags_q`, which reads 0x0002. Bit 1 always reads 1, and bits 3, 5 and 15:12 always read 0.
- R12: All outputs are registered. A change on the inputs appears only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| op_sel | input | 4 | Function code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| flag_wr | input | 1 | Capture status flags on this edge |
| ctl_set | input | 3 | Set strobes for TF, IF, DF |
| ctl_clr | input | 3 | Clear strobes for TF, IF, DF |
| result_q | output | 16 | Registered result |
| carry_q | output | 1 | Registered carry, borrow or shifted-out bit |
| zero_q | output | 1 | Registered zero indication |
| a_gt_b_q | output | 1 | Registered unsigned A greater than B |
| flags_q | output | 16 | Flag word |

## Verification
The hardest situation to reach from the ports is a decrement that must leave CF alone while AF and OF still update. It only shows an error when CF already holds a value that differs from the decrement's own borrow. The stimulus interleaves all ten functions under a pseudo-random update strobe, so CF arrives at decrements carrying both values left by earlier adds, shifts and logic operations. The sweep covers every byte-mode A value against sixteen B values that include the sign and nibble boundaries. Word mode runs corner operands such as 0x7FFF and 0x8000 followed by random pairs, while the control-flag strobes fire, sometimes together, alongside the arithmetic.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_W = 16;
  localparam int CTL_N  = 3;

  localparam int FB_CF = 0;
  localparam int FB_ONE = 1;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_CTL = 8;   // TF, IF, DF occupy 8..10
  localparam int FB_OF = 11;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_DEC = 4'd2;
  localparam logic [3:0] OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4;
  localparam logic [3:0] OP_XOR = 4'd5;
  localparam logic [3:0] OP_NOT = 4'd6;
  localparam logic [3:0] OP_SHL = 4'd7;
  localparam logic [3:0] OP_SHR = 4'd8;
  localparam logic [3:0] OP_SAR = 4'd9;

  typedef struct packed {
    logic cout;     // carry, borrow or shifted-out bit
    logic aux;      // carry/borrow out of bit 3
    logic ovf;      // signed overflow
    logic keep_cf;  // operation must not alter CF
  } alu_stat_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] res,
  output alu_stat_t         stat,
  output logic              sign,
  output logic              zero,
  output logic              parity,
  output logic              a_gt_b
);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] mask, top_mask, am, bm, bsel, raw;
  logic [DATA_W:0]   sum, diff;
  logic              ta, tb, tr, is_add, is_sub, cout;

  always_comb begin
    mask     = byte_mode ? LOW_MASK : '1;
    top_mask = byte_mode ? (ONE << (BYTE_W-1)) : (ONE << (DATA_W-1));
    am       = a & mask;
    bm       = b & mask;
    bsel     = (op == OP_DEC) ? ONE : bm;
    sum      = {1'b0, am} + {1'b0, bsel};
    diff     = {1'b0, am} - {1'b0, bsel};
    ta       = |(am & top_mask);
    tb       = |(bsel & top_mask);
  end

  always_comb begin
    raw    = '0;
    cout   = 1'b0;
    is_add = 1'b0;
    is_sub = 1'b0;
    case (op)
      OP_ADD: begin
        raw    = sum[DATA_W-1:0];
        cout   = byte_mode ? sum[BYTE_W] : sum[DATA_W];
        is_add = 1'b1;
      end
      OP_SUB, OP_DEC: begin
        raw    = diff[DATA_W-1:0];
        cout   = byte_mode ? diff[BYTE_W] : diff[DATA_W];
        is_sub = 1'b1;
      end
      OP_AND: raw = am & bm;
      OP_OR:  raw = am | bm;
      OP_XOR: raw = am ^ bm;
      OP_NOT: raw = ~am;
      OP_SHL: begin
        raw  = am << 1;
        cout = ta;
      end
      OP_SHR: begin
        raw  = am >> 1;
        cout = am[0];
      end
      OP_SAR: begin
        raw  = (am >> 1) | (am & top_mask);
        cout = am[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    res          = raw & mask;
    tr           = |(res & top_mask);
    stat.cout    = cout;
    stat.aux     = (is_add | is_sub) & (am[4] ^ bsel[4] ^ raw[4]);
    stat.ovf     = (is_add & (ta == tb) & (tr != ta)) |
                   (is_sub & (ta != tb) & (tr != ta));
    stat.keep_cf = (op == OP_DEC);
    sign         = tr;
    zero         = (res == '0);
    parity       = ~^res[7:0];
    a_gt_b       = (am > bm);
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  alu_stat_t         stat,
  input  logic              sign,
  input  logic              zero,
  input  logic              parity,
  input  logic [CTL_N-1:0]  ctl_set,
  input  logic [CTL_N-1:0]  ctl_clr,
  output logic [FLAG_W-1:0] flags
);
  logic cf, pf, af, zf, sf, of_q;
  logic [CTL_N-1:0] ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cf <= 1'b0; pf <= 1'b0; af <= 1'b0;
      zf <= 1'b0; sf <= 1'b0; of_q <= 1'b0;
    end else if (upd) begin
      if (!stat.keep_cf) cf <= stat.cout;
      pf   <= parity;
      af   <= stat.aux;
      zf   <= zero;
      sf   <= sign;
      of_q <= stat.ovf;
    end
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)             ctl[i] <= 1'b0;
      else if (ctl_set[i]) ctl[i] <= 1'b1;
      else if (ctl_clr[i]) ctl[i] <= 1'b0;
    end
  end

  always_comb begin
    flags                      = '0;
    flags[FB_CF]               = cf;
    flags[FB_ONE]              = 1'b1;
    flags[FB_PF]               = pf;
    flags[FB_AF]               = af;
    flags[FB_ZF]               = zf;
    flags[FB_SF]               = sf;
    flags[FB_CTL +: CTL_N]     = ctl;
    flags[FB_OF]               = of_q;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [3:0]        op_sel,
  input  logic              byte_mode,
  input  logic              flag_wr,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  output logic [DATA_W-1:0] result_q,
  output logic              carry_q,
  output logic              zero_q,
  output logic              a_gt_b_q,
  output logic [15:0]       flags_q
);
  logic [DATA_W-1:0] res;
  alu_stat_t         stat;
  logic              sign, zero, parity, a_gt_b;

  alu_core #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_core (
    .a(a_in), .b(b_in), .op(op_sel), .byte_mode(byte_mode),
    .res(res), .stat(stat), .sign(sign), .zero(zero),
    .parity(parity), .a_gt_b(a_gt_b)
  );

  flag_reg u_flags (
    .clk(clk), .rst(rst), .upd(flag_wr), .stat(stat),
    .sign(sign), .zero(zero), .parity(parity),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      carry_q  <= 1'b0;
      zero_q   <= 1'b0;
      a_gt_b_q <= 1'b0;
    end else begin
      result_q <= res;
      carry_q  <= stat.cout;
      zero_q   <= zero;
      a_gt_b_q <= a_gt_b;
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_flag_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [3:0]  op_sel,
  input logic        byte_mode,
  input logic        flag_wr,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic [15:0] result_q,
  input logic [15:0] flags_q
);
  // R11: fixed bits of the flag word
  a_r11_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_q[1] && !flags_q[3] && !flags_q[5] && flags_q[15:12] == 4'h0));

  // R10: control flags hold without strobes
  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags_q[10:8]));

  // R9: status flags hold without update
  a_r9_status_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> ($stable(flags_q[7:0]) && $stable(flags_q[11])));

  // R2: decrement never alters CF
  a_r2_dec_keeps_cf: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && op_sel == OP_DEC) |=> flags_q[0] == $past(flags_q[0]));

  // R3: logic operations clear CF and OF
  a_r3_logic_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR || op_sel == OP_NOT))
      |=> (!flags_q[0] && !flags_q[11]));

  // R5: ZF agrees with the registered result
  a_r5_zf_matches: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> flags_q[6] == (result_q == 16'h0000));

  // R7: upper byte is zero in byte mode
  a_r7_byte_upper: assert property (@(posedge clk) disable iff (rst)
    byte_mode |=> result_q[15:8] == 8'h00);
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .byte_mode(byte_mode),
  .flag_wr(flag_wr), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
  .result_q(result_q), .flags_q(flags_q)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0, b_in = '0;
  logic [3:0]  op_sel = '0;
  logic        byte_mode = 1'b0, flag_wr = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] result_q, flags_q;
  logic        carry_q, zero_q, a_gt_b_q;

  int compared = 0;
  int mismatched = 0;

  alu_flag_unit dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
    .byte_mode(byte_mode), .flag_wr(flag_wr), .ctl_set(ctl_set),
    .ctl_clr(ctl_clr), .result_q(result_q), .carry_q(carry_q),
    .zero_q(zero_q), .a_gt_b_q(a_gt_b_q), .flags_q(flags_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model state
  logic m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
  logic [2:0] m_ctl = '0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  function automatic logic [15:0] byte_b(input int j);
    case (j)
      0: return 16'h00;  1: return 16'h01;  2: return 16'h0F;  3: return 16'h10;
      4: return 16'h7F;  5: return 16'h80;  6: return 16'hFF;  7: return 16'h08;
      8: return 16'h33;  9: return 16'h5A; 10: return 16'h81; 11: return 16'hA7;
      12: return 16'hC0; 13: return 16'hEE; 14: return 16'h7E; default: return 16'hF1;
    endcase
  endfunction

  // drive one vector at a falling edge, check at the next falling edge
  task automatic run_vec(input logic [15:0] a, input logic [15:0] b, input int op,
                         input logic bm, input logic wr,
                         input logic [2:0] cs, input logic [2:0] cc);
    int n, msk, av, bv, r, c, af, ov, sa, sb, sr, ones, gt;
    string tag;
    n   = bm ? 8 : 16;
    msk = bm ? 32'hFF : 32'hFFFF;
    av  = int'(a) & msk;
    bv  = int'(b) & msk;
    c = 0; af = 0; ov = 0; r = 0;
    case (op)
      0: begin r = (av + bv) & msk; c = ((av + bv) >> n) & 1;
               af = (((av & 15) + (bv & 15)) >> 4) & 1; tag = "R1 add"; end
      1: begin r = (av - bv) & msk; c = (av < bv) ? 1 : 0;
               af = ((av & 15) < (bv & 15)) ? 1 : 0; tag = "R1 sub"; end
      2: begin r = (av - 1) & msk; c = (av == 0) ? 1 : 0;
               af = ((av & 15) == 0) ? 1 : 0; tag = "R2 dec"; end
      3: begin r = av & bv; tag = "R3 and"; end
      4: begin r = av | bv; tag = "R3 or"; end
      5: begin r = av ^ bv; tag = "R3 xor"; end
      6: begin r = (~av) & msk; tag = "R3 not"; end
      7: begin r = (av << 1) & msk; c = (av >> (n-1)) & 1; tag = "R4 shl"; end
      8: begin r = av >> 1; c = av & 1; tag = "R4 shr"; end
      default: begin r = (av >> 1) | (av & (1 << (n-1))); c = av & 1; tag = "R4 sar"; end
    endcase
    sa = (av >> (n-1)) & 1;
    sb = ((op == 2 ? 1 : bv) >> (n-1)) & 1;
    sr = (r >> (n-1)) & 1;
    if (op == 0) ov = (sa == sb && sr != sa) ? 1 : 0;
    if (op == 1 || op == 2) ov = (sa != sb && sr != sa) ? 1 : 0;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
    gt = (av > bv) ? 1 : 0;
    if (bm) tag = {tag, " R7 byte"};

    a_in = a; b_in = b; op_sel = 4'(op); byte_mode = bm;
    flag_wr = wr; ctl_set = cs; ctl_clr = cc;

    if (wr) begin
      if (op != 2) m_cf = c[0];
      m_pf = (ones % 2 == 0); m_af = af[0]; m_zf = (r == 0);
      m_sf = sr[0]; m_of = ov[0];
    end
    for (int k = 0; k < 3; k++) begin
      if (cs[k]) m_ctl[k] = 1'b1;
      else if (cc[k]) m_ctl[k] = 1'b0;
    end

    @(negedge clk);
    chk({tag, " result"}, 32'(result_q), 32'(r));
    chk({tag, " carry out"}, 32'(carry_q), 32'(c));
    chk("R8 zero/greater", {30'd0, zero_q, a_gt_b_q}, {30'd0, (r == 0), gt[0]});
    chk(wr ? {tag, " CF"} : "R9 CF held", 32'(flags_q[0]), 32'(m_cf));
    chk(wr ? "R5 ZF/SF/PF" : "R9 ZF/SF/PF held",
        {29'd0, flags_q[6], flags_q[7], flags_q[2]}, {29'd0, m_zf, m_sf, m_pf});
    chk(wr ? "R6 AF/OF" : "R9 AF/OF held",
        {30'd0, flags_q[4], flags_q[11]}, {30'd0, m_af, m_of});
    chk("R10 control flags", 32'(flags_q[10:8]), 32'(m_ctl));
    chk("R11 fixed bits", {16'd0, flags_q & 16'hF02A}, 32'h0002);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 reset flags", 32'(flags_q), 32'h0002);
    chk("R11 reset outputs", {13'd0, result_q, carry_q, zero_q, a_gt_b_q}, 32'd0);

    // R12: outputs move only after the clock edge
    a_in = 16'h0003; b_in = 16'h0004; op_sel = 4'd0; flag_wr = 1'b1;
    #1;
    chk("R12 no change before edge", 32'(result_q), 32'd0);
    @(negedge clk);
    chk("R12 registered sum", 32'(result_q), 32'd7);
    m_pf = 0; m_zf = 0; m_sf = 0; m_cf = 0; m_af = 0; m_of = 0; // 7: three ones

    // R10: set wins over clear, then clear alone, then arithmetic leaves them
    run_vec(16'h0001, 16'h0001, 0, 1'b0, 1'b1, 3'b111, 3'b111);
    run_vec(16'hFFFF, 16'h0001, 0, 1'b0, 1'b1, 3'b000, 3'b010);
    run_vec(16'h8000, 16'h0001, 1, 1'b0, 1'b1, 3'b000, 3'b000);

    // R2: decrement with CF set beforehand, then cleared beforehand
    run_vec(16'hFFFF, 16'h0001, 0, 1'b0, 1'b1, 3'b000, 3'b000);
    run_vec(16'h0000, 16'h0000, 2, 1'b0, 1'b1, 3'b000, 3'b000);
    run_vec(16'h0001, 16'h0001, 3, 1'b0, 1'b1, 3'b000, 3'b000);
    run_vec(16'h0000, 16'h0000, 2, 1'b0, 1'b1, 3'b000, 3'b000);

    // word corners
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        for (int op = 0; op < 10; op++) begin
          logic [15:0] cv [7];
          cv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h000F, 16'h0010};
          run_vec(cv[i], cv[j], op, 1'b0, 1'b1, 3'b000, 3'b000);
        end
      end
    end

    // byte sweep: every A, sixteen B values, all functions, junk in upper bytes
    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 16; j++) begin
        for (int op = 0; op < 10; op++) begin
          step_rng();
          run_vec({rng[15:8], 8'(a)}, {rng[23:16], byte_b(j)[7:0]}, op, 1'b1,
                  rng[2:0] != 3'b000,
                  (rng[27:24] == 4'h0) ? rng[30:28] : 3'b000,
                  (rng[7:4] == 4'h0) ? rng[11:9] : 3'b000);
        end
      end
    end

    // word random
    for (int i = 0; i < 3000; i++) begin
      for (int op = 0; op < 10; op++) begin
        logic [15:0] av, bv;
        step_rng(); av = rng[15:0];
        step_rng(); bv = rng[31:16];
        run_vec(av, bv, op, 1'b0, rng[1:0] != 2'b00,
                (rng[8:5] == 4'h0) ? rng[11:9] : 3'b000,
                (rng[15:12] == 4'h0) ? rng[4:2] : 3'b000);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule